// File: doc/BRIEF.md
# Qualified Programmable Event Counter

This block is one programmable performance-monitoring counter slice. Every clock it sees a few event lanes. Each lane carries a strobe, an 8-bit event code, an 8-bit unit-mask tag and a small per-cycle amount. The lanes that match the configured code and mask are summed into a per-cycle event number. The current privilege level arrives on its own input.

A configuration register holds the event select, the mask, the threshold, the invert, edge, kernel-level, user-level and interrupt enables, and a global enable. The per-cycle event number is first filtered by privilege. It is then either added in full or turned into a one-bit condition by a threshold compare, which can be inverted and can be made rising-edge only. The result is accumulated into a 48-bit counter that software can load at any time.

When the counter wraps past all ones, a sticky overflow flag is set. That flag can raise an interrupt. The block is meant to be replicated once per counter; it does not chain into a neighbouring counter.

Top module: `pmc_slice`

## Requirements
- R1: A lane is selected when its strobe is high, its 8-bit code equals the configured event select, and the bitwise AND of its unit-mask tag with the configured mask is nonzero. The per-cycle event number is the sum of the amounts of the selected lanes.
- R2: With threshold 0, the counter adds the full per-cycle event number, and the invert bit has no effect.
- R3: With a nonzero threshold and invert clear, the counter adds exactly one in a cycle whose event number is greater than or equal to the threshold, and nothing otherwise.
- R4: With a nonzero threshold and invert set, the counter adds exactly one in a cycle whose event number is below the threshold, including a cycle with no events.
- R5: In edge mode the counter adds one only when the qualified condition goes from false to true. For threshold 0 the condition is "event number nonzero". The condition history is cleared whenever counting is disabled, so re-enabling during a busy period counts a new occurrence.
- R6: Privilege level 0 is counted only if the kernel enable is set, and levels 1 to 3 only if the user enable is set. With both enables clear, all levels are counted. In a filtered cycle nothing is added, even when invert is set.
- R7: While the global enable is clear, the counter holds its value.
- R8: A counter write loads the written value on the next clock, and it wins over an increment in the same cycle.
- R9: When an increment carries out of bit 47, the counter wraps modulo 2^48 and the overflow flag is set. The flag stays set until the clear input is pulsed. A set in the same cycle wins over the clear.
- R10: The interrupt output is high exactly when the overflow flag is set and the interrupt enable is set.
- R11: A configuration write takes effect in the cycle after the write strobe. Events arriving in the write cycle are qualified with the old settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lane_valid | input | NUM_LANES | Per-lane event strobe |
| lane_code | input | NUM_LANES*8 | Per-lane event code, lane i at bits [8i+7:8i] |
| lane_umask | input | NUM_LANES*8 | Per-lane unit-mask tag |
| lane_amt | input | NUM_LANES*AMT_W | Per-lane amount of events this cycle |
| priv_level | input | 2 | Current privilege level, 0 = kernel |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_evsel | input | 8 | Event select code |
| cfg_umask | input | 8 | Unit mask |
| cfg_thresh | input | THR_W | Per-cycle threshold, 0 = add full count |
| cfg_invert | input | 1 | Invert threshold compare |
| cfg_edge | input | 1 | Rising-edge-only counting |
| cfg_os | input | 1 | Count at privilege level 0 |
| cfg_usr | input | 1 | Count at privilege levels 1 to 3 |
| cfg_int_en | input | 1 | Interrupt enable |
| cfg_enable | input | 1 | Global counting enable |
| cnt_we | input | 1 | Counter write strobe |
| cnt_wdata | input | CNT_W | Counter write value |
| ovf_clr | input | 1 | Clear overflow flag |
| count | output | CNT_W | Current counter value |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Overflow interrupt |

## Verification
Two situations are hard to reach from the ports. The first is the carry out of a 48-bit counter, which could never be reached by counting. The stimulus preloads the counter through the software write, just below the wrap point, and then injects a multi-event cycle. The result must wrap to a small value and set the flag and interrupt together. The second is the edge history being cleared by a disable. For that, one event lane is held busy continuously while the configuration is written to disable and then to re-enable counting. A second occurrence must be counted without the input ever falling.

// File: rtl/pmc_slice_pkg.sv
package pmc_slice_pkg;
  localparam int CODE_W = 8;
  localparam int THR_W  = 8;

  typedef struct packed {
    logic [CODE_W-1:0] evsel;
    logic [CODE_W-1:0] umask;
    logic [THR_W-1:0]  thresh;
    logic              invert;
    logic              edge_mode;
    logic              os_en;
    logic              usr_en;
    logic              int_en;
    logic              enable;
  } pmc_cfg_t;
endpackage

// File: rtl/pmc_lane_match.sv
module pmc_lane_match
  import pmc_slice_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int AMT_W     = 4,
  parameter int SUM_W     = 6
) (
  input  logic [NUM_LANES-1:0]        lane_valid,
  input  logic [NUM_LANES*CODE_W-1:0] lane_code,
  input  logic [NUM_LANES*CODE_W-1:0] lane_umask,
  input  logic [NUM_LANES*AMT_W-1:0]  lane_amt,
  input  logic [CODE_W-1:0]           sel_code,
  input  logic [CODE_W-1:0]           sel_umask,
  output logic [SUM_W-1:0]            ev_sum
);
  logic [NUM_LANES-1:0] hit;

  // One comparator per lane: code equality plus mask overlap.
  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    assign hit[g] = lane_valid[g]
                  && (lane_code[g*CODE_W +: CODE_W] == sel_code)
                  && ((lane_umask[g*CODE_W +: CODE_W] & sel_umask) != '0);
  end

  always_comb begin
    ev_sum = '0;
    for (int i = 0; i < NUM_LANES; i++) begin
      if (hit[i]) ev_sum = ev_sum + SUM_W'(lane_amt[i*AMT_W +: AMT_W]);
    end
  end
endmodule

// File: rtl/pmc_qualify.sv
module pmc_qualify
  import pmc_slice_pkg::*;
#(
  parameter int SUM_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [THR_W-1:0] thresh,
  input  logic             invert,
  input  logic             edge_mode,
  input  logic             os_en,
  input  logic             usr_en,
  input  logic [1:0]       priv_level,
  input  logic [SUM_W-1:0] ev_sum,
  output logic [SUM_W-1:0] incr
);
  localparam int CMP_W = (SUM_W > THR_W) ? SUM_W : THR_W;

  logic             priv_ok;
  logic             thr_zero;
  logic             cmp_hit;
  logic             cond;
  logic             prev_q;
  logic [CMP_W-1:0] sum_x;
  logic [CMP_W-1:0] thr_x;

  // Neither privilege class enabled means both are counted.
  always_comb begin
    if (!os_en && !usr_en)    priv_ok = 1'b1;
    else if (priv_level == 0) priv_ok = os_en;
    else                      priv_ok = usr_en;
  end

  assign sum_x    = CMP_W'(ev_sum);
  assign thr_x    = CMP_W'(thresh);
  assign thr_zero = (thresh == '0);
  assign cmp_hit  = invert ? (sum_x < thr_x) : (sum_x >= thr_x);
  assign cond     = enable && priv_ok && (thr_zero ? (ev_sum != '0) : cmp_hit);

  always_comb begin
    if (!enable || !priv_ok) incr = '0;
    else if (edge_mode)      incr = SUM_W'(cond && !prev_q);
    else if (thr_zero)       incr = ev_sum;
    else                     incr = SUM_W'(cond);
  end

  // Condition history; forced false while counting is disabled.
  always_ff @(posedge clk) begin
    if (rst)         prev_q <= 1'b0;
    else if (enable) prev_q <= cond;
    else             prev_q <= 1'b0;
  end

  // R5: after an edge-mode increment, a held condition adds nothing more.
  assert_edge_once_R5: assert property (@(posedge clk) disable iff (rst)
    (edge_mode && incr != '0) |=> (incr == '0 || !edge_mode));
endmodule

// File: rtl/pmc_accum.sv
module pmc_accum #(
  parameter int CNT_W = 48,
  parameter int INC_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [INC_W-1:0] incr,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             ovf_clr,
  input  logic             int_en,
  output logic [CNT_W-1:0] count,
  output logic             ovf,
  output logic             irq
);
  logic [CNT_W:0] sum_full;
  logic           carry;
  logic           ovf_next;

  assign sum_full = {1'b0, count} + (CNT_W+1)'(incr);
  assign carry    = sum_full[CNT_W];
  assign ovf_next = (ovf && !ovf_clr) || (carry && !wr_en);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      ovf   <= 1'b0;
      irq   <= 1'b0;
    end else begin
      count <= wr_en ? wr_data : sum_full[CNT_W-1:0];
      ovf   <= ovf_next;
      irq   <= ovf_next && int_en;
    end
  end

  // R9: a carry without a write sets the flag.
  assert_carry_sets_flag_R9: assert property (@(posedge clk) disable iff (rst)
    (carry && !wr_en) |=> ovf);
  // R9: the flag is sticky until cleared.
  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (ovf && !ovf_clr) |=> ovf);
endmodule

// File: rtl/pmc_slice.sv
module pmc_slice
  import pmc_slice_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int AMT_W     = 4,
  parameter int CNT_W     = 48
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_LANES-1:0]        lane_valid,
  input  logic [NUM_LANES*CODE_W-1:0] lane_code,
  input  logic [NUM_LANES*CODE_W-1:0] lane_umask,
  input  logic [NUM_LANES*AMT_W-1:0]  lane_amt,
  input  logic [1:0]                  priv_level,
  input  logic                        cfg_we,
  input  logic [CODE_W-1:0]           cfg_evsel,
  input  logic [CODE_W-1:0]           cfg_umask,
  input  logic [THR_W-1:0]            cfg_thresh,
  input  logic                        cfg_invert,
  input  logic                        cfg_edge,
  input  logic                        cfg_os,
  input  logic                        cfg_usr,
  input  logic                        cfg_int_en,
  input  logic                        cfg_enable,
  input  logic                        cnt_we,
  input  logic [CNT_W-1:0]            cnt_wdata,
  input  logic                        ovf_clr,
  output logic [CNT_W-1:0]            count,
  output logic                        ovf_flag,
  output logic                        irq
);
  localparam int MAX_SUM = NUM_LANES * ((1 << AMT_W) - 1);
  localparam int SUM_W   = $clog2(MAX_SUM + 1);

  pmc_cfg_t         cfg_q;
  logic [SUM_W-1:0] ev_sum;
  logic [SUM_W-1:0] incr;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (cfg_we) begin
      cfg_q.evsel     <= cfg_evsel;
      cfg_q.umask     <= cfg_umask;
      cfg_q.thresh    <= cfg_thresh;
      cfg_q.invert    <= cfg_invert;
      cfg_q.edge_mode <= cfg_edge;
      cfg_q.os_en     <= cfg_os;
      cfg_q.usr_en    <= cfg_usr;
      cfg_q.int_en    <= cfg_int_en;
      cfg_q.enable    <= cfg_enable;
    end
  end

  pmc_lane_match #(.NUM_LANES(NUM_LANES), .AMT_W(AMT_W), .SUM_W(SUM_W)) u_match (
    .lane_valid (lane_valid),
    .lane_code  (lane_code),
    .lane_umask (lane_umask),
    .lane_amt   (lane_amt),
    .sel_code   (cfg_q.evsel),
    .sel_umask  (cfg_q.umask),
    .ev_sum     (ev_sum)
  );

  pmc_qualify #(.SUM_W(SUM_W)) u_qual (
    .clk        (clk),
    .rst        (rst),
    .enable     (cfg_q.enable),
    .thresh     (cfg_q.thresh),
    .invert     (cfg_q.invert),
    .edge_mode  (cfg_q.edge_mode),
    .os_en      (cfg_q.os_en),
    .usr_en     (cfg_q.usr_en),
    .priv_level (priv_level),
    .ev_sum     (ev_sum),
    .incr       (incr)
  );

  pmc_accum #(.CNT_W(CNT_W), .INC_W(SUM_W)) u_acc (
    .clk     (clk),
    .rst     (rst),
    .incr    (incr),
    .wr_en   (cnt_we),
    .wr_data (cnt_wdata),
    .ovf_clr (ovf_clr),
    .int_en  (cfg_q.int_en),
    .count   (count),
    .ovf     (ovf_flag),
    .irq     (irq)
  );

  // R8: a software write lands on the next clock regardless of events.
  assert_write_wins_R8: assert property (@(posedge clk) disable iff (rst)
    cnt_we |=> (count == $past(cnt_wdata)));
  // R7: disabled counting holds the value.
  assert_hold_disabled_R7: assert property (@(posedge clk) disable iff (rst)
    (!cfg_q.enable && !cnt_we) |=> $stable(count));
  // R3: threshold or edge mode adds at most one per cycle.
  assert_unit_step_R3: assert property (@(posedge clk) disable iff (rst)
    (!cnt_we && (cfg_q.edge_mode || cfg_q.thresh != '0))
      |=> ((count - $past(count)) <= CNT_W'(1)));
  // R10: the interrupt is never high without the overflow flag.
  assert_irq_needs_flag_R10: assert property (@(posedge clk) disable iff (rst)
    irq |-> ovf_flag);
endmodule

// File: tb/tb_pmc_slice.sv
module tb_pmc_slice;
  localparam int NL = 4;
  localparam int AW = 4;
  localparam int CW = 48;

  logic          clk = 1'b0;
  logic          rst;
  logic [NL-1:0]   lane_valid;
  logic [NL*8-1:0] lane_code, lane_umask;
  logic [NL*AW-1:0] lane_amt;
  logic [1:0]    priv_level;
  logic          cfg_we, cfg_invert, cfg_edge, cfg_os, cfg_usr, cfg_int_en, cfg_enable;
  logic [7:0]    cfg_evsel, cfg_umask, cfg_thresh;
  logic          cnt_we, ovf_clr;
  logic [CW-1:0] cnt_wdata, count;
  logic          ovf_flag, irq;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  pmc_slice #(.NUM_LANES(NL), .AMT_W(AW), .CNT_W(CW)) dut (
    .clk(clk), .rst(rst), .lane_valid(lane_valid), .lane_code(lane_code),
    .lane_umask(lane_umask), .lane_amt(lane_amt), .priv_level(priv_level),
    .cfg_we(cfg_we), .cfg_evsel(cfg_evsel), .cfg_umask(cfg_umask),
    .cfg_thresh(cfg_thresh), .cfg_invert(cfg_invert), .cfg_edge(cfg_edge),
    .cfg_os(cfg_os), .cfg_usr(cfg_usr), .cfg_int_en(cfg_int_en),
    .cfg_enable(cfg_enable), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
    .ovf_clr(ovf_clr), .count(count), .ovf_flag(ovf_flag), .irq(irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_lane(input int i, input logic v, input logic [7:0] c,
                          input logic [7:0] m, input logic [AW-1:0] a);
    lane_valid[i]          = v;
    lane_code[i*8 +: 8]    = c;
    lane_umask[i*8 +: 8]   = m;
    lane_amt[i*AW +: AW]   = a;
  endtask

  task automatic clear_lanes();
    lane_valid = '0; lane_code = '0; lane_umask = '0; lane_amt = '0;
  endtask

  task automatic set_cfg(input logic [7:0] ev, input logic [7:0] um, input logic [7:0] thr,
                         input logic inv, input logic edg, input logic os, input logic usr,
                         input logic ie, input logic en);
    cfg_evsel = ev; cfg_umask = um; cfg_thresh = thr; cfg_invert = inv; cfg_edge = edg;
    cfg_os = os; cfg_usr = usr; cfg_int_en = ie; cfg_enable = en; cfg_we = 1'b1;
    tick(1);
    cfg_we = 1'b0;
  endtask

  task automatic wr_cnt(input logic [CW-1:0] v);
    cnt_wdata = v; cnt_we = 1'b1;
    tick(1);
    cnt_we = 1'b0;
  endtask

  task automatic t_reset();
    chk("R9 reset count", count, 0);
    chk("R9 reset flag", ovf_flag, 0);
    chk("R10 reset irq", irq, 0);
  endtask

  task automatic t_match();
    set_cfg(8'h3C, 8'h01, 8'd0, 0, 0, 0, 0, 0, 1);
    wr_cnt('0);
    set_lane(0, 1, 8'h3C, 8'h01, 4'd3);
    set_lane(1, 1, 8'h3C, 8'h02, 4'd5);
    set_lane(2, 1, 8'h3D, 8'h01, 4'd7);
    set_lane(3, 0, 8'h3C, 8'h01, 4'd9);
    tick(1);
    chk("R1 only matching lane counted", count, 3);
    set_lane(1, 1, 8'h3C, 8'h03, 4'd5);
    tick(1);
    chk("R2 full sum added", count, 11);
    clear_lanes();
    set_cfg(8'h3C, 8'h01, 8'd0, 1, 0, 0, 0, 0, 1);
    set_lane(0, 1, 8'h3C, 8'h01, 4'd3);
    set_lane(1, 1, 8'h3C, 8'h03, 4'd5);
    tick(1);
    clear_lanes();
    chk("R2 invert ignored at threshold 0", count, 19);
  endtask

  task automatic t_thresh();
    set_cfg(8'h24, 8'h0F, 8'd4, 0, 0, 0, 0, 0, 1);
    wr_cnt('0);
    set_lane(0, 1, 8'h24, 8'h01, 4'd3); tick(1);
    chk("R3 below threshold", count, 0);
    set_lane(0, 1, 8'h24, 8'h01, 4'd4); tick(1);
    chk("R3 equal threshold", count, 1);
    set_lane(1, 1, 8'h24, 8'h08, 4'd5); tick(1);
    clear_lanes();
    chk("R3 above threshold adds one", count, 2);
    set_cfg(8'h24, 8'h0F, 8'd4, 1, 0, 0, 0, 0, 1);
    wr_cnt('0);
    set_lane(0, 1, 8'h24, 8'h01, 4'd3); tick(1);
    chk("R4 below threshold counts", count, 1);
    set_lane(0, 1, 8'h24, 8'h01, 4'd4); tick(1);
    chk("R4 at threshold no count", count, 1);
    clear_lanes(); tick(1);
    chk("R4 idle cycle counts", count, 2);
  endtask

  task automatic t_edge();
    set_cfg(8'h14, 8'h01, 8'd1, 0, 1, 0, 0, 0, 1);
    wr_cnt('0);
    set_lane(0, 1, 8'h14, 8'h01, 4'd1); tick(5);
    clear_lanes(); tick(2);
    set_lane(0, 1, 8'h14, 8'h01, 4'd1); tick(3);
    clear_lanes(); tick(1);
    chk("R5 two busy periods", count, 2);
    wr_cnt('0);
    set_lane(0, 1, 8'h14, 8'h01, 4'd1); tick(3);
    chk("R5 first occurrence", count, 1);
    set_cfg(8'h14, 8'h01, 8'd1, 0, 1, 0, 0, 0, 0);
    tick(2);
    chk("R7 held while disabled", count, 1);
    set_cfg(8'h14, 8'h01, 8'd1, 0, 1, 0, 0, 0, 1);
    tick(3);
    clear_lanes();
    chk("R5 history cleared by disable", count, 2);
  endtask

  task automatic t_priv();
    set_cfg(8'h5C, 8'h01, 8'd0, 0, 0, 1, 0, 0, 1);
    wr_cnt('0);
    priv_level = 2'd0; set_lane(0, 1, 8'h5C, 8'h01, 4'd2); tick(1);
    priv_level = 2'd2; tick(1);
    chk("R6 kernel only", count, 2);
    clear_lanes();
    set_cfg(8'h5C, 8'h01, 8'd0, 0, 0, 0, 1, 0, 1);
    priv_level = 2'd0; set_lane(0, 1, 8'h5C, 8'h01, 4'd2); tick(1);
    priv_level = 2'd3; set_lane(0, 1, 8'h5C, 8'h01, 4'd1); tick(1);
    chk("R6 user only", count, 3);
    clear_lanes();
    set_cfg(8'h5C, 8'h01, 8'd0, 0, 0, 0, 0, 0, 1);
    priv_level = 2'd0; set_lane(0, 1, 8'h5C, 8'h01, 4'd1); tick(1);
    priv_level = 2'd1; tick(1);
    chk("R6 neither means both", count, 5);
    clear_lanes();
    set_cfg(8'h5C, 8'h01, 8'd4, 1, 0, 0, 1, 0, 1);
    priv_level = 2'd0; tick(1);
    chk("R6 filtered cycle with invert", count, 5);
    priv_level = 2'd1; tick(1);
    chk("R6 allowed cycle with invert", count, 6);
    priv_level = 2'd0;
  endtask

  task automatic t_write();
    set_cfg(8'hB1, 8'h01, 8'd0, 0, 0, 0, 0, 0, 1);
    set_lane(0, 1, 8'hB1, 8'h01, 4'd5);
    wr_cnt(48'h12_3456_789A);
    chk("R8 write beats increment", count, 48'h12_3456_789A);
    tick(1);
    clear_lanes();
    chk("R8 counting resumes", count, 48'h12_3456_789F);
  endtask

  task automatic t_overflow();
    set_cfg(8'hC0, 8'h01, 8'd0, 0, 0, 0, 0, 1, 1);
    wr_cnt(48'hFFFF_FFFF_FFFE);
    set_lane(0, 1, 8'hC0, 8'h01, 4'd3); tick(1);
    clear_lanes();
    chk("R9 wrap value", count, 1);
    chk("R9 flag set", ovf_flag, 1);
    chk("R10 irq raised", irq, 1);
    tick(2);
    chk("R9 flag sticky", ovf_flag, 1);
    ovf_clr = 1'b1; tick(1); ovf_clr = 1'b0;
    chk("R9 flag cleared", ovf_flag, 0);
    chk("R10 irq dropped", irq, 0);
    set_cfg(8'hC0, 8'h01, 8'd0, 0, 0, 0, 0, 0, 1);
    wr_cnt(48'hFFFF_FFFF_FFFF);
    set_lane(0, 1, 8'hC0, 8'h01, 4'd1); tick(1);
    clear_lanes();
    chk("R9 flag without interrupt", ovf_flag, 1);
    chk("R10 irq masked", irq, 0);
    ovf_clr = 1'b1; tick(1); ovf_clr = 1'b0;
  endtask

  task automatic t_cfg_timing();
    set_cfg(8'hA0, 8'hFF, 8'd0, 0, 0, 0, 0, 0, 1);
    wr_cnt('0);
    set_lane(0, 1, 8'hB0, 8'h01, 4'd6);
    set_cfg(8'hB0, 8'hFF, 8'd0, 0, 0, 0, 0, 0, 1);
    chk("R11 old config in write cycle", count, 0);
    tick(1);
    clear_lanes();
    chk("R11 new config next cycle", count, 6);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; clear_lanes(); priv_level = 2'd0;
    cfg_we = 0; cfg_evsel = 0; cfg_umask = 0; cfg_thresh = 0; cfg_invert = 0;
    cfg_edge = 0; cfg_os = 0; cfg_usr = 0; cfg_int_en = 0; cfg_enable = 0;
    cnt_we = 0; cnt_wdata = '0; ovf_clr = 0;
    tick(3);
    rst = 1'b0;
    tick(1);
    t_reset();
    t_match();
    t_thresh();
    t_edge();
    t_priv();
    t_write();
    t_overflow();
    t_cfg_timing();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule